// File: doc/BRIEF.md
# IrDA SIR Pulse Modulator

This block sits on the transmit path between a UART serial output and an infrared LED driver. It converts NRZ serial bits into the short light pulses used by low-speed infrared links. A logic-zero bit becomes one pulse. A logic-one bit leaves the LED dark for the whole bit. With modulation switched off, the block passes the UART's NRZ stream straight through to the pin.

A small control register selects one of three behaviours:

- NRZ pass-through.
- Pulses scaled to the programmed bit time: 3 of the 16 oversampling ticks in each bit.
- A fixed low-power pulse of at least 1.6 µs, timed from the system clock and independent of the baud setting.

The register accepts changes only while the UART's transmitter and receiver are both disabled. A write at any other time is dropped silently.

The UART supplies its 16x bit-clock enable, which already carries the effect of the baud divisor. It also supplies a strobe marking the first tick of each bit, and the serial data bit.

Top module: `irda_sir_mod`

## Requirements
- R1: With the enable bit (control bit 0) at 0, `ir_tx` equals `uart_txd` in the same cycle, for both 0 and 1.
- R2: With the enable bit at 1, a bit whose data is 1 produces no pulse: `ir_tx` stays low for the whole bit time.
- R3: With enable at 1 and low-power (control bit 1) at 0, a zero bit starting at a cycle where `bit_start` and `tick16` are both high drives `ir_tx` high from the next cycle. The pulse lasts exactly 3 `tick16` periods, whatever the tick spacing.
- R4: With enable at 1 and low-power at 1, a zero bit drives `ir_tx` high for exactly LP_CYC clock cycles. LP_CYC = ceil(1.6 µs × clock frequency), which is 400 at 250 MHz. The pulse length does not change with the tick spacing.
- R5: The register holds enable in bit 0 and low-power in bit 1. Writes to bits 7 to 2 are ignored, and those bits always read 0.
- R6: After reset the register reads 0x00, so the block starts in NRZ pass-through.
- R7: A register write while `uart_tx_en` or `uart_rx_en` is high is dropped, and the register keeps its previous value.
- R8: While modulation is enabled and no zero pulse is in progress, `ir_tx` is low, including when the line idles at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick16 | input | 1 | 16x bit-clock enable from the UART baud generator |
| bit_start | input | 1 | High on the tick16 cycle that opens a new bit |
| uart_txd | input | 1 | NRZ serial data from the UART |
| uart_tx_en | input | 1 | UART transmitter enabled |
| uart_rx_en | input | 1 | UART receiver enabled |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register read data |
| ir_tx | output | 1 | LED drive, high means LED on |

## Verification
The hardest situation to reach is showing that the low-power pulse ignores the baud timing. The tick spacing never appears in the output of that mode, so a single baud setting would prove nothing. The bench therefore sends zero bits at two different tick spacings in each pulsed mode. Scaled pulses must change length with the spacing, while low-power pulses must stay at exactly 400 cycles. The blocked-write rule is also reached deliberately: the bench raises each UART enable in turn and confirms through the read port that the write had no effect.

// File: rtl/irda_sir_pkg.sv
// Package: shared register layout and timing helpers for the IrDA SIR modulator.
// Assumes the control register is 8 bits wide with two live bits.
package irda_sir_pkg;
    localparam int REG_W      = 8;
    localparam int BIT_EN     = 0;   // modulation enable
    localparam int BIT_LP     = 1;   // fixed low-power pulse select
    localparam logic [REG_W-1:0] CTRL_MASK = 8'h03;
    localparam int TICK_PULSE = 3;   // ticks of 16 per bit that carry light

    // Clock cycles needed for a 1.6 us pulse, rounded up.
    function automatic int lp_cycles(input int clk_khz);
        longint num;
        num = longint'(clk_khz) * 16 + 64'd9999;
        return int'(num / 64'd10000);
    endfunction
endpackage

// File: rtl/irda_ctrl_reg.sv
// Control register: holds enable and low-power bits.
// Assumes writes are single-cycle strobes; updates only while the UART is idle.
module irda_ctrl_reg
    import irda_sir_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    input  logic             uart_busy,
    output logic [REG_W-1:0] ctrl_q
);
    // Store masked write data when the UART is idle; reserved bits stay zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (reg_wr && !uart_busy)
            ctrl_q <= reg_wdata & CTRL_MASK;
    end

    // R7: a write while busy leaves the register untouched
    a_r7_locked_write: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && uart_busy) |=> $stable(ctrl_q));
endmodule

// File: rtl/irda_tick_pulse.sv
// Scaled pulse timer: holds its output for TICK_PULSE tick16 periods after a start.
// Assumes start coincides with a tick16 cycle at the opening of a bit.
module irda_tick_pulse
    import irda_sir_pkg::*;
#(
    parameter int TICKS = TICK_PULSE
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic start,
    input  logic tick16,
    output logic on
);
    localparam int TCW = $clog2(TICKS + 1);
    localparam logic [TCW-1:0] LAST = TCW'(TICKS - 1);

    logic [TCW-1:0] tcnt;

    // Count ticks from the start edge and drop the pulse on the last one.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            on   <= 1'b0;
            tcnt <= '0;
        end else if (start) begin
            on   <= 1'b1;
            tcnt <= '0;
        end else if (on && tick16) begin
            if (tcnt == LAST)
                on <= 1'b0;
            else
                tcnt <= tcnt + 1'b1;
        end
    end

    // R3: the tick count never runs past the pulse length
    a_r3_tick_bound: assert property (@(posedge clk) disable iff (!rst_n)
        on |-> (tcnt <= LAST));
endmodule

// File: rtl/irda_fixed_pulse.sv
// Fixed pulse timer: holds its output for CYCLES system clocks after a start.
// Assumes CYCLES >= 1; the baud tick plays no part in its timing.
module irda_fixed_pulse #(
    parameter int CYCLES = 400
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic start,
    output logic on
);
    localparam int LCW = $clog2(CYCLES + 1);
    localparam logic [LCW-1:0] LOAD = LCW'(CYCLES - 1);

    logic [LCW-1:0] lcnt;

    // Load on start, count down each clock, release at zero.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            on   <= 1'b0;
            lcnt <= '0;
        end else if (start) begin
            on   <= 1'b1;
            lcnt <= LOAD;
        end else if (on) begin
            if (lcnt == '0)
                on <= 1'b0;
            else
                lcnt <= lcnt - 1'b1;
        end
    end

    // R4: while cycles remain the pulse is held
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n || clr)
        (on && lcnt != '0 && !start) |=> on);
endmodule

// File: rtl/irda_sir_mod.sv
// Top: NRZ-to-IrDA SIR transmit modulator with control register.
// Assumes tick16 is the UART 16x enable and bit_start marks the first tick of each bit.
module irda_sir_mod
    import irda_sir_pkg::*;
#(
    parameter int CLK_KHZ = 250000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick16,
    input  logic             bit_start,
    input  logic             uart_txd,
    input  logic             uart_tx_en,
    input  logic             uart_rx_en,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic             ir_tx
);
    localparam int LP_CYC = lp_cycles(CLK_KHZ);

    logic [REG_W-1:0] ctrl_q;
    logic mod_en, lp_sel, zero_start, tick_on, fixed_on, pulse;

    irda_ctrl_reg u_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .uart_busy (uart_tx_en | uart_rx_en),
        .ctrl_q    (ctrl_q)
    );

    // Decode mode bits and detect the opening tick of a zero bit.
    always_comb begin
        mod_en     = ctrl_q[BIT_EN];
        lp_sel     = ctrl_q[BIT_LP];
        zero_start = mod_en && tick16 && bit_start && !uart_txd;
    end

    irda_tick_pulse u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (!mod_en || lp_sel),
        .start  (zero_start && !lp_sel),
        .tick16 (tick16),
        .on     (tick_on)
    );

    irda_fixed_pulse #(.CYCLES(LP_CYC)) u_fixed (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (!mod_en || !lp_sel),
        .start (zero_start && lp_sel),
        .on    (fixed_on)
    );

    // Select the pin source: raw NRZ, or the active pulse timer.
    always_comb begin
        pulse     = lp_sel ? fixed_on : tick_on;
        ir_tx     = mod_en ? pulse : uart_txd;
        reg_rdata = ctrl_q;
    end

    // R2: a one bit opening with the LED dark keeps it dark next cycle
    a_r2_one_dark: assert property (@(posedge clk) disable iff (!rst_n)
        (mod_en && tick16 && bit_start && uart_txd && !ir_tx) |=> !ir_tx);
    // R5: reserved bits never read back as one
    a_r5_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[REG_W-1:2] == '0);
endmodule

// File: tb/sim_irda_sir_mod.sv
module sim_irda_sir_mod;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick16 = 1'b0, bit_start = 1'b0, uart_txd = 1'b1;
    logic uart_tx_en = 1'b0, uart_rx_en = 1'b0, reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic ir_tx;
    int n_run = 0, n_fail = 0;
    int hi_cnt = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;  // 250 MHz

    irda_sir_mod u0 (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .bit_start(bit_start),
        .uart_txd(uart_txd), .uart_tx_en(uart_tx_en), .uart_rx_en(uart_rx_en),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ir_tx(ir_tx)
    );

    always @(negedge clk) if (ir_tx === 1'b1) hi_cnt++;

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [7:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    // One full bit of 16 ticks spaced tdiv clocks; returns highs seen.
    task automatic send_bit(input logic b, input int tdiv, output int highs);
        int base;
        @(negedge clk);
        base = hi_cnt;
        uart_txd = b;
        for (int t = 0; t < 16; t++) begin
            for (int c = 0; c < tdiv; c++) begin
                tick16 = (c == 0);
                bit_start = (c == 0) && (t == 0);
                @(negedge clk);
            end
        end
        tick16 = 1'b0; bit_start = 1'b0; uart_txd = 1'b1;
        highs = hi_cnt - base;
    endtask

    task automatic t_reset();
        @(negedge clk); check("R6 reset rdata", reg_rdata, 0);
        check("R6 reset nrz", ir_tx, 1);
    endtask

    task automatic t_regs();
        wr_reg(8'hFF); check("R5 write FF", reg_rdata, 3);
        wr_reg(8'hFE); check("R5 write FE", reg_rdata, 2);
        wr_reg(8'h00); check("R5 write 00", reg_rdata, 0);
    endtask

    task automatic t_nrz();
        @(negedge clk); uart_txd = 1'b0; #1 check("R1 nrz zero", ir_tx, 0);
        uart_txd = 1'b1; #1 check("R1 nrz one", ir_tx, 1);
    endtask

    task automatic t_locked();
        uart_tx_en = 1'b1; wr_reg(8'h01);
        check("R7 tx busy", reg_rdata, 0);
        uart_tx_en = 1'b0; uart_rx_en = 1'b1; wr_reg(8'h03);
        check("R7 rx busy", reg_rdata, 0);
        uart_rx_en = 1'b0;
        #1 check("R7 nrz kept", ir_tx, 1);
    endtask

    task automatic t_scaled();
        int h;
        wr_reg(8'h01);
        @(negedge clk); check("R8 idle dark", ir_tx, 0);
        send_bit(1'b0, 4, h); check("R3 zero tdiv4", h, 12);
        send_bit(1'b0, 7, h); check("R3 zero tdiv7", h, 21);
        send_bit(1'b1, 4, h); check("R2 one scaled", h, 0);
        repeat (20) @(negedge clk);
        check("R8 idle after", ir_tx, 0);
    endtask

    task automatic t_lowpower();
        int h;
        wr_reg(8'h03);
        send_bit(1'b0, 40, h); check("R4 lp tdiv40", h, 400);
        send_bit(1'b0, 30, h); check("R4 lp tdiv30", h, 400);
        send_bit(1'b1, 30, h); check("R2 one lp", h, 0);
        check("R8 lp idle", ir_tx, 0);
        wr_reg(8'h00);
        #1 check("R1 back to nrz", ir_tx, 1);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        t_reset();
        t_regs();
        t_nrz();
        t_locked();
        t_scaled();
        t_lowpower();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule